// File: doc/BRIEF.md
# Level-Sensitive Queue Interrupt Aggregator

This block drives the single legacy interrupt line of a storage controller that serves up to 64 completion queues. It holds one pending flag per queue. The flag is raised when the controller posts completions to a queue whose interrupt is enabled. It is dropped when a host head-doorbell write leaves that queue empty. A 32-bit host mask hides queues 0 to 31 from the line. The mask has a set port and a clear port, each written with a bit pattern of 1s. The line is a held level: it stays high while any unmasked queue has work the host has not consumed, so no single completion can be missed.

While vector-message interrupt mode is active, the line is forced low and queue events do not change the pending flags. Event inputs are plain strobes and are taken on every cycle. There is no back-pressure on them. A completion strobe and a doorbell strobe may arrive in the same cycle. The register write port is accepted on every cycle as well.

Top module: `lvl_irq_agg`

## Requirements
- R1: A synchronous reset clears every pending flag and the mask. While reset is held, `irq_o` is low and `mask_o` reads 0.
- R2: A completion strobe with `post_ien_i` high, while vector mode is off, raises the pending flag of `post_qid_i`. `irq_o` goes high on the following clock if that queue is unmasked.
- R3: A completion strobe with `post_ien_i` low leaves the pending flags unchanged.
- R4: A doorbell strobe with `db_empty_i` and `db_ien_i` both high, while vector mode is off, drops the pending flag of `db_qid_i`. `irq_o` falls on the following clock if no other unmasked flag remains.
- R5: A doorbell strobe with `db_empty_i` low, or with `db_ien_i` low, leaves the pending flags unchanged.
- R6: `irq_o` equals the OR over all queues of the pending flag ANDed with NOT the mask bit. Mask bit k covers queue k for k below 32. Queues 32 to 63 are never masked.
- R7: A write at byte offset 0x0C sets every mask bit whose write-data bit is 1 and leaves the other mask bits as they were. `mask_o` shows the new mask, and `irq_o` is re-evaluated, on the following clock.
- R8: A write at byte offset 0x10 clears every mask bit whose write-data bit is 1. `mask_o` and `irq_o` reflect the change on the following clock.
- R9: While `vec_mode_i` is high, `irq_o` is low on the following clock, and completion and doorbell strobes change no pending flag. After the mode ends, `irq_o` again reflects the flags held before the mode began.
- R10: If a raise and a drop hit the same queue in the same cycle, the raise wins.
- R11: Writes at any offset other than 0x0C and 0x10 leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vec_mode_i | input | 1 | Vector-message interrupt mode is active |
| post_valid_i | input | 1 | Completions posted this cycle |
| post_qid_i | input | 6 | Queue that received the completions |
| post_ien_i | input | 1 | Interrupt enable of that queue |
| db_valid_i | input | 1 | Head doorbell written this cycle |
| db_qid_i | input | 6 | Queue whose head doorbell was written |
| db_ien_i | input | 1 | Interrupt enable of that queue |
| db_empty_i | input | 1 | The new head equals the tail |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| mask_o | output | 32 | Current mask, as read back at the clear offset |
| irq_o | output | 1 | Level interrupt line |

## Verification
A pending flag that is stuck or lost shows on `irq_o` one clock after the event that should have moved it. It also shows later, when a mask or doorbell change exposes the flag, or fails to expose it. The bench therefore hides and reveals single queues with the mask, in the low half and the high half of the queue range. It also leaves vector mode and checks that the line returns to the state it held before the mode began. A wrong mask bit is visible at once on `mask_o` in the cycle after the write.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  typedef enum logic [1:0] {
    MOP_NONE = 2'd0,
    MOP_SET  = 2'd1,
    MOP_CLR  = 2'd2
  } mask_op_e;
endpackage

// File: rtl/lvl_irq_evt_dec.sv
module lvl_irq_evt_dec #(
  parameter int unsigned NUM_Q = 64,
  parameter int unsigned QID_W = $clog2(NUM_Q)
) (
  input  logic             vec_mode_i,
  input  logic             post_valid_i,
  input  logic [QID_W-1:0] post_qid_i,
  input  logic             post_ien_i,
  input  logic             db_valid_i,
  input  logic [QID_W-1:0] db_qid_i,
  input  logic             db_ien_i,
  input  logic             db_empty_i,
  output logic [NUM_Q-1:0] set_vec_o,
  output logic [NUM_Q-1:0] clr_vec_o
);
  logic post_go, db_go;
  assign post_go = post_valid_i & post_ien_i & ~vec_mode_i;
  assign db_go   = db_valid_i & db_ien_i & db_empty_i & ~vec_mode_i;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    assign set_vec_o[i] = post_go & (post_qid_i == QID_W'(i));
    assign clr_vec_o[i] = db_go & (db_qid_i == QID_W'(i));
  end

  always_comb begin
    assert ($onehot0(set_vec_o) && $onehot0(clr_vec_o))
      else $error("assert_onehot_events_R2");
  end
endmodule

// File: rtl/lvl_irq_pend.sv
module lvl_irq_pend #(
  parameter int unsigned NUM_Q = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_Q-1:0] set_vec_i,
  input  logic [NUM_Q-1:0] clr_vec_i,
  output logic [NUM_Q-1:0] pend_q_o,
  output logic [NUM_Q-1:0] pend_nxt_o
);
  logic [NUM_Q-1:0] pend_q;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_bit
    // raise has priority over drop on the same queue
    assign pend_nxt_o[i] = set_vec_i[i] | (pend_q[i] & ~clr_vec_i[i]);
    always_ff @(posedge clk) begin
      if (rst) pend_q[i] <= 1'b0;
      else     pend_q[i] <= pend_nxt_o[i];
    end
  end
  assign pend_q_o = pend_q;

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (set_vec_i != '0) |=> ((pend_q & $past(set_vec_i)) == $past(set_vec_i)));
  assert_drop_R4: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec_i & ~set_vec_i) != '0) |=> ((pend_q & $past(clr_vec_i & ~set_vec_i)) == '0));
endmodule

// File: rtl/lvl_irq_mask.sv
module lvl_irq_mask
  import lvl_irq_pkg::*;
#(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter logic [7:0]  SET_OFF = 8'h0C,
  parameter logic [7:0]  CLR_OFF = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  mask_q_o,
  output logic [REG_W-1:0]  mask_nxt_o
);
  mask_op_e op;
  logic [REG_W-1:0] mask_q;

  always_comb begin
    op = MOP_NONE;
    if (wr_i && addr_i == ADDR_W'(SET_OFF)) op = MOP_SET;
    else if (wr_i && addr_i == ADDR_W'(CLR_OFF)) op = MOP_CLR;
  end

  always_comb begin
    unique case (op)
      MOP_SET: mask_nxt_o = mask_q | wdata_i;
      MOP_CLR: mask_nxt_o = mask_q & ~wdata_i;
      default: mask_nxt_o = mask_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nxt_o;
  end
  assign mask_q_o = mask_q;

  assert_mask_set_R7: assert property (@(posedge clk) disable iff (rst)
    (op == MOP_SET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  assert_mask_clr_R8: assert property (@(posedge clk) disable iff (rst)
    (op == MOP_CLR) |=> ((mask_q & $past(wdata_i)) == '0));
  assert_other_offset_R11: assert property (@(posedge clk) disable iff (rst)
    (op == MOP_NONE) |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/lvl_irq_pin.sv
module lvl_irq_pin #(
  parameter int unsigned NUM_Q = 64,
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vec_mode_i,
  input  logic [NUM_Q-1:0] pend_i,
  input  logic [REG_W-1:0] mask_i,
  output logic             irq_o
);
  logic [NUM_Q-1:0] live;
  logic irq_q;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_live
    if (i < REG_W) begin : g_maskable
      assign live[i] = pend_i[i] & ~mask_i[i];
    end else begin : g_open
      assign live[i] = pend_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ~vec_mode_i & (|live);
  end
  assign irq_o = irq_q;

  assert_vec_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    vec_mode_i |=> !irq_q);
endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg #(
  parameter int unsigned NUM_Q   = 64,
  parameter int unsigned QID_W   = $clog2(NUM_Q),
  parameter int unsigned REG_W   = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter logic [7:0]  SET_OFF = 8'h0C,
  parameter logic [7:0]  CLR_OFF = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vec_mode_i,
  input  logic              post_valid_i,
  input  logic [QID_W-1:0]  post_qid_i,
  input  logic              post_ien_i,
  input  logic              db_valid_i,
  input  logic [QID_W-1:0]  db_qid_i,
  input  logic              db_ien_i,
  input  logic              db_empty_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  mask_o,
  output logic              irq_o
);
  logic [NUM_Q-1:0] set_vec, clr_vec, pend_q, pend_nxt, mask_ext;
  logic [REG_W-1:0] mask_nxt;

  lvl_irq_evt_dec #(.NUM_Q(NUM_Q), .QID_W(QID_W)) u_dec (
    .vec_mode_i(vec_mode_i), .post_valid_i(post_valid_i), .post_qid_i(post_qid_i),
    .post_ien_i(post_ien_i), .db_valid_i(db_valid_i), .db_qid_i(db_qid_i),
    .db_ien_i(db_ien_i), .db_empty_i(db_empty_i),
    .set_vec_o(set_vec), .clr_vec_o(clr_vec));

  lvl_irq_pend #(.NUM_Q(NUM_Q)) u_pend (
    .clk(clk), .rst(rst), .set_vec_i(set_vec), .clr_vec_i(clr_vec),
    .pend_q_o(pend_q), .pend_nxt_o(pend_nxt));

  lvl_irq_mask #(.REG_W(REG_W), .ADDR_W(ADDR_W), .SET_OFF(SET_OFF), .CLR_OFF(CLR_OFF)) u_mask (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .mask_q_o(mask_o), .mask_nxt_o(mask_nxt));

  lvl_irq_pin #(.NUM_Q(NUM_Q), .REG_W(REG_W)) u_pin (
    .clk(clk), .rst(rst), .vec_mode_i(vec_mode_i), .pend_i(pend_nxt),
    .mask_i(mask_nxt), .irq_o(irq_o));

  for (genvar i = 0; i < NUM_Q; i++) begin : g_mext
    if (i < REG_W) begin : g_m
      assign mask_ext[i] = mask_o[i];
    end else begin : g_z
      assign mask_ext[i] = 1'b0;
    end
  end

  assert_line_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((pend_q & ~mask_ext) != '0));
  assert_vec_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    vec_mode_i |=> (pend_q == $past(pend_q)));
  assert_no_ien_R3: assert property (@(posedge clk) disable iff (rst)
    (!post_valid_i || !post_ien_i) && !(db_valid_i && db_ien_i && db_empty_i)
      |=> (pend_q == $past(pend_q)));
endmodule

// File: tb/sim_lvl_irq_agg.sv
module sim_lvl_irq_agg;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, vec_mode = 1'b0;
  logic post_v = 1'b0, post_e = 1'b0, db_v = 1'b0, db_e = 1'b0, db_m = 1'b0, wr = 1'b0;
  logic [5:0] post_q = '0, db_q = '0;
  logic [7:0] waddr = '0;
  logic [31:0] wdata = '0, mask_o;
  logic irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [63:0] m_pend = '0;
  logic [31:0] m_mask = '0;
  bit q_irq[$];
  logic [31:0] q_mask[$];
  string q_tag[$];

  lvl_irq_agg u0 (
    .clk(clk), .rst(rst), .vec_mode_i(vec_mode), .post_valid_i(post_v), .post_qid_i(post_q),
    .post_ien_i(post_e), .db_valid_i(db_v), .db_qid_i(db_q), .db_ien_i(db_e),
    .db_empty_i(db_m), .reg_wr_i(wr), .reg_addr_i(waddr), .reg_wdata_i(wdata),
    .mask_o(mask_o), .irq_o(irq_o));

  always #(PERIOD/2) clk = ~clk;

  task automatic step(input bit pv, input int pq, input bit pe,
                      input bit dv, input int dq, input bit de, input bit dm,
                      input bit wv, input logic [7:0] wa, input logic [31:0] wd,
                      input bit vm, input string tag);
    logic [63:0] s, c;
    @(negedge clk);
    post_v = pv; post_q = 6'(pq); post_e = pe;
    db_v = dv; db_q = 6'(dq); db_e = de; db_m = dm;
    wr = wv; waddr = wa; wdata = wd; vec_mode = vm;
    s = (pv && pe && !vm) ? (64'd1 << pq) : 64'd0;
    c = (dv && de && dm && !vm) ? (64'd1 << dq) : 64'd0;
    m_pend = (m_pend & ~c) | s;
    if (wv && wa == 8'h0C) m_mask = m_mask | wd;
    else if (wv && wa == 8'h10) m_mask = m_mask & ~wd;
    q_irq.push_back(!vm && ((m_pend & ~{32'd0, m_mask}) != 64'd0));
    q_mask.push_back(m_mask);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input bit vm, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 32'd0, vm, tag);
  endtask

  // monitor: pops one expected item per driven cycle
  always begin
    @(posedge clk);
    #(PERIOD/5);
    if (q_irq.size() > 0) begin
      bit ei;
      logic [31:0] em;
      string t;
      ei = q_irq.pop_front(); em = q_mask.pop_front(); t = q_tag.pop_front();
      checks++;
      if (irq_o !== ei || mask_o !== em) begin
        fails++;
        $display("FAIL %s: irq=%0b mask=%h expected irq=%0b mask=%h", t, irq_o, mask_o, ei, em);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(PERIOD/5);
    checks++;
    if (irq_o !== 1'b0 || mask_o !== 32'd0) begin
      fails++;
      $display("FAIL R1: irq=%0b mask=%h expected irq=0 mask=00000000", irq_o, mask_o);
    end
    @(negedge clk); rst = 1'b0;
    step(1, 3, 1, 0, 0, 0, 0, 0, 8'h00, 32'd0, 0, "R2");
    idle(0, "R2");
    step(0, 0, 0, 1, 3, 1, 1, 0, 8'h00, 32'd0, 0, "R4");
    step(1, 5, 0, 0, 0, 0, 0, 0, 8'h00, 32'd0, 0, "R3");
    step(1, 40, 1, 0, 0, 0, 0, 0, 8'h00, 32'd0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h0C, 32'hFFFF_FFFF, 0, "R7");
    step(0, 0, 0, 1, 40, 0, 1, 0, 8'h00, 32'd0, 0, "R5");
    step(0, 0, 0, 1, 40, 1, 0, 0, 8'h00, 32'd0, 0, "R5");
    step(0, 0, 0, 1, 40, 1, 1, 0, 8'h00, 32'd0, 0, "R4");
    step(1, 7, 1, 0, 0, 0, 0, 0, 8'h00, 32'd0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h10, 32'h0000_0080, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h0C, 32'd0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h08, 32'hFFFF_FFFF, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h14, 32'h0000_0080, 0, "R11");
    idle(1, "R9");
    step(0, 0, 0, 1, 7, 1, 1, 0, 8'h00, 32'd0, 1, "R9");
    step(1, 9, 1, 0, 0, 0, 0, 0, 8'h00, 32'd0, 1, "R9");
    idle(0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h10, 32'hFFFF_FFFF, 0, "R8");
    step(0, 0, 0, 1, 7, 1, 1, 0, 8'h00, 32'd0, 0, "R9");
    step(1, 12, 1, 1, 12, 1, 1, 0, 8'h00, 32'd0, 0, "R10");
    idle(0, "R10");
    step(1, 12, 1, 0, 0, 0, 0, 1, 8'h0C, 32'h0000_1000, 0, "R7");
    step(1, 63, 1, 0, 0, 0, 0, 0, 8'h00, 32'd0, 0, "R6");
    step(0, 0, 0, 1, 63, 1, 1, 0, 8'h00, 32'd0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h10, 32'h0000_1000, 0, "R8");
    idle(0, "R8");
    repeat (3) @(posedge clk);
    #(PERIOD/2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule